// File: doc/BRIEF.md
# Local Interrupt Priority Arbiter

This block is the pending/in-service core of a per-processor interrupt controller. It keeps one request bit and one in-service bit for each of 256 vectors. It picks the highest-numbered pending vector and weighs that vector's priority class against the processor's current priority. From that result it drives a single interrupt line toward the core. The processor priority is formed from a programmable task priority and from the class of the highest vector that is currently being serviced.

When the core acknowledges, the block answers one cycle later in one of three ways:

- It returns the winning vector and moves it from pending to in-service.
- It returns a programmable spurious vector, when something is pending but its class is too low.
- It reports that no interrupt is present.

An end-of-interrupt strobe retires the highest in-service vector. A small write port loads the task-priority value and the spurious-vector value. The spurious-vector value carries the software enable bit.

Top module: `lpa_arbiter`

## Requirements
- R1: After reset, the pending and in-service sets are empty, the task priority is 0, and the spurious register holds 0x0FF (enable clear, spurious vector 0xFF). In this state `irqOut` is 0 and `ackDone` is 0.
- R2: The pending candidate is the highest-numbered vector set in the pending set. Acknowledges taken in sequence deliver higher-numbered vectors first.
- R3: Processor priority (PP) is the task priority when its class (bits 7:4) is greater than or equal to the class of the highest in-service vector. Otherwise PP is that in-service class in bits 7:4, with 0 in bits 3:0. A candidate is blocked when PP is nonzero and the candidate's class is less than or equal to PP's class.
- R4: `irqOut` is 1 only when the enable bit (spurious register bit 8) is 1, a candidate exists, and the candidate is not blocked.
- R5: An acknowledge made while the enable bit is 0, or while the pending set is empty, answers `ackKind`=0 (none) with `ackVec`=0 and changes no state.
- R6: An acknowledge that finds a blocked candidate answers `ackKind`=2 (spurious) with `ackVec` equal to spurious register bits 7:0. The pending and in-service sets stay unchanged.
- R7: An acknowledge that finds an unblocked candidate answers `ackKind`=1 (vector) with `ackVec` equal to the candidate. The candidate's bit moves from the pending set to the in-service set.
- R8: An end-of-interrupt strobe clears the highest set in-service bit, which lowers PP accordingly.
- R9: Requests for vectors 0 to 15 are ignored.
- R10: A request for a vector and an acknowledge that clears that same vector in the same cycle leave the vector pending, because the set wins.
- R11: All responses are registered. `ackDone`, `ackKind` and `ackVec` appear one cycle after `ackReq`. `irqOut` reflects a state change one cycle after the edge that made the change.
- R12: The write port (`wrEn`) loads `wrData[7:0]` into the task priority when `wrSel`=0, and loads `wrData[8:0]` into the spurious register when `wrSel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request pulse for vector `reqVec` |
| reqVec | input | 8 | Requested vector number |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 = task priority, 1 = spurious register |
| wrData | input | 9 | Write data (bit 8 = enable for the spurious register) |
| ackReq | input | 1 | Acknowledge strobe from the core |
| eoiReq | input | 1 | End-of-interrupt strobe |
| irqOut | output | 1 | Interrupt line to the core |
| ackDone | output | 1 | Acknowledge answer valid |
| ackKind | output | 2 | 0 none, 1 vector, 2 spurious |
| ackVec | output | 8 | Answered vector |

## Verification
Some properties are checked on every cycle by the assertions:

- Vectors 0 to 15 never become pending.
- An accepted vector lands in the in-service set.
- A request always sets its bit, even when an acknowledge clears that bit in the same cycle.
- End-of-interrupt removes the top in-service bit.
- A disabled controller never raises `irqOut`.
- Answers of kind none and spurious carry the right vector.

The scenarios alone show the priority arithmetic. The bench sweeps every pair of task class and vector class. It sweeps every legal vector through the request, acknowledge and end-of-interrupt cycle. It also covers ordering among several pending vectors, blocking by an in-service vector, and the one-cycle latency of the line.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_VEC  = 2'd1,
    ACK_SPUR = 2'd2
  } ackKind_t;

  // Strobes issued by the control to the datapath for one cycle
  typedef struct packed {
    logic reqSet;   // latch reqVec into the pending set
    logic accept;   // move the candidate from pending to in-service
    logic eoi;      // retire the top in-service vector
    logic wrTpr;    // load task priority
    logic wrSvr;    // load spurious/enable register
  } lpaStrobe_t;

endpackage

// File: rtl/lpa_top_find.sv
// Highest-set-bit finder built as a balanced tree of 2:1 selects.
module lpa_top_find #(
  parameter int W  = 256,
  localparam int IW = $clog2(W),
  localparam int LVL = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] top
);

  for (genvar l = 0; l <= LVL; l++) begin : lv
    localparam int N = W >> l;
    logic [N-1:0]  v;
    logic [IW-1:0] ix [N];
    if (l == 0) begin : leaf
      for (genvar i = 0; i < N; i++) begin : lf
        assign v[i]  = bits[i];
        assign ix[i] = IW'(i);
      end
    end else begin : node
      for (genvar i = 0; i < N; i++) begin : nd
        assign v[i]  = lv[l-1].v[2*i] | lv[l-1].v[2*i+1];
        assign ix[i] = lv[l-1].v[2*i+1] ? lv[l-1].ix[2*i+1] : lv[l-1].ix[2*i];
      end
    end
  end

  assign any = lv[LVL].v[0];
  assign top = lv[LVL].ix[0];

endmodule

// File: rtl/lpa_datapath.sv
module lpa_datapath
  import lpa_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  lpaStrobe_t       stb,
  input  logic [VEC_W-1:0] reqVec,
  input  logic [VEC_W:0]   wrData,
  output logic             irrAny,
  output logic [VEC_W-1:0] irrTop,
  output logic             blocked,
  output logic             swEn,
  output logic [VEC_W-1:0] spurVec
);

  localparam int FIRST_VEC = 1 << CLASS_W;

  logic [NUM_VEC-1:0] irrReg, isrReg, irrNext, isrNext;
  logic [VEC_W-1:0]   tprReg;
  logic [VEC_W:0]     svrReg;
  logic               isrAny;
  logic [VEC_W-1:0]   isrTop;
  logic [VEC_W-1:0]   ppr;
  logic [CLASS_W-1:0] tprClass, isrClass;

  lpa_top_find #(.W(NUM_VEC)) irrFind (.bits(irrReg), .any(irrAny), .top(irrTop));
  lpa_top_find #(.W(NUM_VEC)) isrFind (.bits(isrReg), .any(isrAny), .top(isrTop));

  assign tprClass = tprReg[VEC_W-1 -: CLASS_W];
  assign isrClass = isrAny ? isrTop[VEC_W-1 -: CLASS_W] : '0;

  always_comb begin
    if (tprClass >= isrClass) ppr = tprReg;
    else                      ppr = {isrClass, {(VEC_W-CLASS_W){1'b0}}};
  end

  assign blocked = (ppr != '0) && (irrTop[VEC_W-1 -: CLASS_W] <= ppr[VEC_W-1 -: CLASS_W]);
  assign swEn    = svrReg[VEC_W];
  assign spurVec = svrReg[VEC_W-1:0];

  always_comb begin
    irrNext = irrReg;
    isrNext = isrReg;
    if (stb.accept) irrNext[irrTop] = 1'b0;
    if (stb.reqSet) irrNext[reqVec] = 1'b1;   // set wins
    if (stb.eoi && isrAny) isrNext[isrTop] = 1'b0;
    if (stb.accept) isrNext[irrTop] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrReg <= '0;
      isrReg <= '0;
      tprReg <= '0;
      svrReg <= {1'b0, {VEC_W{1'b1}}};
    end else begin
      irrReg <= irrNext;
      isrReg <= isrNext;
      if (stb.wrTpr) tprReg <= wrData[VEC_W-1:0];
      if (stb.wrSvr) svrReg <= wrData;
    end
  end

  // R9
  low_vec_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    irrReg[FIRST_VEC-1:0] == '0);

  // R7
  accept_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.accept |=> isrReg[$past(irrTop)]);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.reqSet |=> irrReg[$past(reqVec)]);

  // R8
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoi && isrAny && !stb.accept) |=> !isrReg[$past(isrTop)]);

endmodule

// File: rtl/lpa_control.sv
module lpa_control
  import lpa_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVec,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic             ackReq,
  input  logic             eoiReq,
  input  logic             irrAny,
  input  logic [VEC_W-1:0] irrTop,
  input  logic             blocked,
  input  logic             swEn,
  input  logic [VEC_W-1:0] spurVec,
  output lpaStrobe_t       stb,
  output logic             irqOut,
  output logic             ackDone,
  output ackKind_t         ackKind,
  output logic [VEC_W-1:0] ackVec
);

  localparam int FIRST_VEC = 1 << CLASS_W;

  ackKind_t         kindNext;
  logic [VEC_W-1:0] vecNext;
  logic             winner;

  assign winner = swEn && irrAny && !blocked;

  always_comb begin
    stb        = '0;
    stb.reqSet = reqValid && (reqVec >= VEC_W'(FIRST_VEC));
    stb.accept = ackReq && winner;
    stb.eoi    = eoiReq;
    stb.wrTpr  = wrEn && !wrSel;
    stb.wrSvr  = wrEn && wrSel;
  end

  always_comb begin
    kindNext = ACK_NONE;
    vecNext  = '0;
    if (swEn && irrAny) begin
      if (blocked) begin
        kindNext = ACK_SPUR;
        vecNext  = spurVec;
      end else begin
        kindNext = ACK_VEC;
        vecNext  = irrTop;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut  <= 1'b0;
      ackDone <= 1'b0;
      ackKind <= ACK_NONE;
      ackVec  <= '0;
    end else begin
      irqOut  <= winner;
      ackDone <= ackReq;
      if (ackReq) begin
        ackKind <= kindNext;
        ackVec  <= vecNext;
      end
    end
  end

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !swEn |=> !irqOut);

  // R5
  empty_ack_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && !irrAny) |=> (ackDone && ackKind == ACK_NONE && ackVec == '0));

  // R6
  spur_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && swEn && irrAny && blocked) |=> (ackKind == ACK_SPUR && ackVec == $past(spurVec)));

  // R11
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> ackDone);

endmodule

// File: rtl/lpa_arbiter.sv
module lpa_arbiter
  import lpa_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVec,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [VEC_W:0]   wrData,
  input  logic             ackReq,
  input  logic             eoiReq,
  output logic             irqOut,
  output logic             ackDone,
  output logic [1:0]       ackKind,
  output logic [VEC_W-1:0] ackVec
);

  lpaStrobe_t       stb;
  logic             irrAny, blocked, swEn;
  logic [VEC_W-1:0] irrTop, spurVec;
  ackKind_t         kindReg;

  lpa_datapath #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqVec(reqVec), .wrData(wrData),
    .irrAny(irrAny), .irrTop(irrTop), .blocked(blocked), .swEn(swEn),
    .spurVec(spurVec)
  );

  lpa_control #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVec(reqVec),
    .wrEn(wrEn), .wrSel(wrSel), .ackReq(ackReq), .eoiReq(eoiReq),
    .irrAny(irrAny), .irrTop(irrTop), .blocked(blocked), .swEn(swEn),
    .spurVec(spurVec), .stb(stb), .irqOut(irqOut), .ackDone(ackDone),
    .ackKind(kindReg), .ackVec(ackVec)
  );

  assign ackKind = kindReg;

endmodule

// File: tb/tb_lpa_arbiter.sv
`timescale 1ns/1ps
module tb_lpa_arbiter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqVec = '0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [8:0] wrData = '0;
  logic       ackReq = 1'b0;
  logic       eoiReq = 1'b0;
  logic       irqOut, ackDone;
  logic [1:0] ackKind;
  logic [7:0] ackVec;

  int total = 0;
  int bad = 0;
  logic [1:0] gotKind;
  logic [7:0] gotVec;

  localparam logic [8:0] SVR_ON = 9'h1E7;

  always #2 clk = ~clk;

  lpa_arbiter dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVec(reqVec),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .ackReq(ackReq),
    .eoiReq(eoiReq), .irqOut(irqOut), .ackDone(ackDone),
    .ackKind(ackKind), .ackVec(ackVec)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic doReq(input int v);
    reqValid = 1'b1; reqVec = 8'(v); cyc(); reqValid = 1'b0;
  endtask

  task automatic doWr(input logic sel, input logic [8:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d; cyc(); wrEn = 1'b0;
  endtask

  task automatic doEoi();
    eoiReq = 1'b1; cyc(); eoiReq = 1'b0;
  endtask

  task automatic doAck(output logic [1:0] k, output logic [7:0] v);
    ackReq = 1'b1; cyc(); ackReq = 1'b0;
    chk("R11 ackDone", int'(ackDone), 1);
    k = ackKind; v = ackVec;
  endtask

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk("R1 irqOut", int'(irqOut), 0);
    chk("R1 ackDone", int'(ackDone), 0);
    rstN = 1'b1;
    cyc();
    doAck(gotKind, gotVec);
    chk("R5 ack empty kind", int'(gotKind), 0);
    chk("R5 ack empty vec", int'(gotVec), 0);

    // R4 / R5 disabled: pending but enable clear
    doWr(1'b1, 9'h0E7);
    doReq(8'h50);
    cyc();
    chk("R4 irq while disabled", int'(irqOut), 0);
    doAck(gotKind, gotVec);
    chk("R5 ack disabled kind", int'(gotKind), 0);
    doWr(1'b1, SVR_ON);   // R12 enable via spurious register
    cyc();
    chk("R4 irq enabled", int'(irqOut), 1);
    doAck(gotKind, gotVec);
    chk("R5 pending kept after disabled ack", int'(gotVec), 8'h50);
    cyc();
    chk("R7 irq drops when set empty", int'(irqOut), 0);
    doEoi();

    // R9 low vectors ignored
    for (int v = 0; v < 16; v++) doReq(v);
    cyc();
    chk("R9 irq for low vectors", int'(irqOut), 0);
    doAck(gotKind, gotVec);
    chk("R9 ack after low vectors", int'(gotKind), 0);

    // R11 irq latency
    doReq(8'h31);
    chk("R11 irq not yet", int'(irqOut), 0);
    cyc();
    chk("R11 irq one cycle later", int'(irqOut), 1);
    doAck(gotKind, gotVec);
    chk("R7 kind", int'(gotKind), 1);
    doEoi();

    // R2 ordering, R3/R8 in-service blocking
    doReq(8'h40);
    doReq(8'h93);
    doAck(gotKind, gotVec);
    chk("R2 highest first", int'(gotVec), 8'h93);
    doReq(8'h85);
    cyc();
    chk("R3 in-service blocks lower class irq", int'(irqOut), 0);
    doAck(gotKind, gotVec);
    chk("R6 spurious kind", int'(gotKind), 2);
    chk("R6 spurious vec", int'(gotVec), 8'hE7);
    doReq(8'hA0);
    doAck(gotKind, gotVec);
    chk("R3 higher class passes", int'(gotVec), 8'hA0);
    doEoi();   // retires A0
    doEoi();   // retires 93
    cyc();
    chk("R8 eoi reopens line", int'(irqOut), 1);
    doAck(gotKind, gotVec);
    chk("R8 next vector", int'(gotVec), 8'h85);
    doEoi();
    doAck(gotKind, gotVec);
    chk("R2 lowest last", int'(gotVec), 8'h40);
    doEoi();

    // R10 set wins over acknowledge clear
    doReq(8'h66);
    ackReq = 1'b1; reqValid = 1'b1; reqVec = 8'h66;
    cyc();
    ackReq = 1'b0; reqValid = 1'b0;
    chk("R10 ack vec", int'(ackVec), 8'h66);
    doAck(gotKind, gotVec);
    chk("R10 still pending, blocked by itself", int'(gotKind), 2);
    doEoi();
    doAck(gotKind, gotVec);
    chk("R10 re-delivered", int'(gotVec), 8'h66);
    doEoi();

    // R3 / R12 sweep: every task class against every vector class
    for (int tc = 0; tc < 16; tc++) begin
      for (int vc = 1; vc < 16; vc++) begin
        logic blk;
        blk = (tc != 0) && (vc <= tc);
        doWr(1'b0, 9'(tc * 16));
        doReq(vc * 16 + 7);
        cyc();
        chk("R3 sweep irq", int'(irqOut), int'(!blk));
        doAck(gotKind, gotVec);
        if (blk) begin
          chk("R6 sweep spurious", int'(gotVec), 8'hE7);
          doWr(1'b0, 9'h000);
          doAck(gotKind, gotVec);
        end
        chk("R7 sweep vector", int'(gotVec), vc * 16 + 7);
        doEoi();
      end
    end
    doWr(1'b0, 9'h000);

    // R7 exhaustive legal vectors
    for (int v = 16; v < 256; v++) begin
      doReq(v);
      doAck(gotKind, gotVec);
      chk("R7 sweep kind", int'(gotKind), 1);
      chk("R7 sweep vec", int'(gotVec), v);
      doEoi();
    end
    cyc();
    chk("R5 end idle", int'(irqOut), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule